// File: doc/BRIEF.md
# Dual-Kernel Lifting Wavelet Line Filter

This block applies a one-dimensional forward discrete wavelet transform to one image line at a time. Samples arrive serially over a valid/ready handshake, with flags that mark the first and the last sample of a line. A mode bit picks either the reversible integer 5/3 kernel, suited to lossless coding, or the irreversible 9/7 kernel in fixed point, suited to lossy coding. The block emits the coefficients of the line in sample order. Each coefficient is tagged as low-pass (even positions) or high-pass (odd positions).

The line is held in an internal buffer. The lifting steps then run in place over it, one coefficient per cycle, alternating between odd positions (predict) and even positions (update). Every product by a kernel constant is built from fixed shifts and additions, so the block has no general multiplier. At both ends of a line the missing neighbour is supplied by mirror extension, and lines of any length from one sample to the buffer depth are accepted. In 9/7 mode, a final stage scales each coefficient by the kernel gain for its band, rounds it to an integer and clips it to the output width.

Top module: `lift_dwt_1d`

## Requirements
- R1: While reset is held and directly after it, `out_valid` is 0 and `in_ready` is 1.
- R2: A line of N accepted samples yields exactly N output beats on consecutive cycles, in sample order. Position i is tagged `out_high` = i mod 2 (0 for low-pass, 1 for high-pass), and only the beat for position N-1 has `out_last` = 1.
- R3: In 5/3 mode (`mode_97` = 0), each odd position gives d = x - floor((xl + xr) / 2), where xl and xr are the even neighbours.
- R4: In 5/3 mode, each even position gives s = x + floor((dl + dr + 2) / 4), where dl and dr are the neighbouring d values, with no scaling. The inverse lifting steps applied to the outputs therefore return the input line exactly.
- R5: In 9/7 mode (`mode_97` = 1), each sample enters as x * 4096. Four steps then run in order, on odd, even, odd and even positions, with the constants -6497, -217, 3616 and 1817. Each step adds floor((C * (left + right) + 2048) / 4096) to the value at the position being updated.
- R6: In 9/7 mode, each output is floor((v * K + 2^23) / 2^24), where v is the lifted value, K = 5039 for high-pass positions and K = 3330 for low-pass positions.
- R7: A neighbour outside the line is replaced by its mirror: position -1 reads position 1, and position N reads position N-2. For a one-sample line both neighbour sums are taken as 0, so in 5/3 mode the sample is passed through unchanged.
- R8: The mode is taken from `mode_97` on the first sample of a line. Changes of `mode_97` during the rest of the line have no effect on its coefficients.
- R9: A sample with `in_sol` = 1 starts a new line at position 0. Samples accepted before it that were not closed by `in_eol` are discarded and produce no output.
- R10: When MAX_LEN samples have been accepted without `in_eol`, the line ends at that sample and is processed.
- R11: After the last sample of a line is accepted, `in_ready` stays 0 until the final coefficient is emitted. Samples offered during that time are not taken and do not change any output.
- R12: Results above 2^(OUT_W-1) - 1 or below -2^(OUT_W-1) are clipped to those limits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_97 | input | 1 | Kernel select: 0 = integer 5/3, 1 = fixed-point 9/7 |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block accepts a sample this cycle |
| in_data | input | IN_W | Signed input sample |
| in_sol | input | 1 | Sample is the first of a line |
| in_eol | input | 1 | Sample is the last of a line |
| out_valid | output | 1 | Coefficient valid |
| out_data | output | OUT_W | Signed coefficient |
| out_high | output | 1 | 1 = high-pass coefficient, 0 = low-pass |
| out_last | output | 1 | Final coefficient of the line |

## Verification
The bench drives the shortest lines (one, two and three samples), odd and even lengths, and full-depth lines. At those sizes a wrong mirror index gives wrong edge coefficients, or makes the block read a buffer entry outside the line. It compares both kernels against an arithmetic model: a misplaced rounding offset shows up as off-by-one coefficients, and a wrong 9/7 step order or swapped band gain gives large mismatches. In 5/3 mode it also inverts the outputs and expects the original samples back. Alternating full-scale input must clip to the limits rather than wrap. A mid-line mode change, a restart by `in_sol`, a line closed only by reaching the buffer depth, and samples offered while the block is busy must each leave the expected sequence intact.

// File: rtl/lift_pkg.sv
// Shared constants and types for the lifting wavelet line filter.
// The 9/7 constants are signed fixed point with FRAC fractional bits.
package lift_pkg;
    localparam int FRAC      = 12;
    localparam int COEF_BITS = 16;
    localparam int LIFT_C97 [4] = '{-6497, -217, 3616, 1817};
    localparam int K_HIGH    = 5039;
    localparam int K_LOW     = 3330;

    typedef enum logic [1:0] {
        ST_COLLECT,
        ST_LIFT,
        ST_OUT
    } lift_state_t;
endpackage

// File: rtl/lift_shift_add_mul.sv
// Multiplies a signed operand by a fixed signed constant.
// The product is a sum of shifted copies of the operand, one for each set
// bit of the constant's magnitude, then negated if the constant is negative.
// Assumes |COEF| < 2**CB and PW is wide enough for the full product.
module lift_shift_add_mul #(
    parameter int AW   = 16,
    parameter int PW   = 32,
    parameter int COEF = 1,
    parameter int CB   = 16
) (
    input  logic signed [AW-1:0] a,
    output logic signed [PW-1:0] p
);
    localparam int          MAG  = (COEF < 0) ? -COEF : COEF;
    localparam logic [CB-1:0] MAGV = CB'(MAG);

    logic signed [PW-1:0] ax;
    logic signed [PW-1:0] acc;

    assign ax = PW'(a);

    // Accumulate the shifted partial terms selected by the constant.
    always_comb begin
        acc = '0;
        for (int k = 0; k < CB; k++) begin
            if (MAGV[k]) acc = acc + (ax <<< k);
        end
        p = (COEF < 0) ? -acc : acc;
    end
endmodule

// File: rtl/lift_line_buf.sv
// Line storage: one write port and three combinational read ports (the
// centre and both neighbours of the position being lifted).
// Contents need no reset; only entries written for the current line are read.
module lift_line_buf #(
    parameter int W     = 28,
    parameter int AW    = 6,
    parameter int DEPTH = 64
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] ra_addr,
    input  logic [AW-1:0] rb_addr,
    input  logic [AW-1:0] rc_addr,
    output logic [W-1:0]  ra_data,
    output logic [W-1:0]  rb_data,
    output logic [W-1:0]  rc_data
);
    logic [W-1:0] mem [DEPTH];

    // Store one sample or one lifted coefficient per cycle.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign ra_data = mem[ra_addr];
    assign rb_data = mem[rb_addr];
    assign rc_data = mem[rc_addr];
endmodule

// File: rtl/lift_step_alu.sv
// One lifting step for one position. In 5/3 mode the step is integer
// predict or update with its rounding offset. In 9/7 mode the step adds the
// rounded fixed-point product of the neighbour sum and the constant for that
// step. The four constant products are separate shift-add trees, and step
// selects among them. Assumes W leaves guard bits, so no step overflows.
module lift_step_alu import lift_pkg::*; #(
    parameter int W = 28
) (
    input  logic                m97,
    input  logic [1:0]          step,
    input  logic                has_nb,
    input  logic signed [W-1:0] c,
    input  logic signed [W-1:0] l,
    input  logic signed [W-1:0] r,
    output logic signed [W-1:0] y
);
    localparam int SW = W + 1;
    localparam int PW = SW + COEF_BITS;

    logic signed [SW-1:0] sum;
    logic signed [PW-1:0] prod [4];
    logic signed [PW-1:0] cx;
    logic signed [PW-1:0] sx;
    logic signed [PW-1:0] inc97;

    assign sum = has_nb ? (SW'(l) + SW'(r)) : '0;

    for (genvar s = 0; s < 4; s++) begin : g_coef
        lift_shift_add_mul #(
            .AW  (SW),
            .PW  (PW),
            .COEF(LIFT_C97[s]),
            .CB  (COEF_BITS)
        ) u_mul (
            .a(sum),
            .p(prod[s])
        );
    end

    // Form the updated value for the selected kernel and step.
    always_comb begin
        cx    = PW'(c);
        sx    = PW'(sum);
        inc97 = (prod[step] + (PW'(1) <<< (FRAC - 1))) >>> FRAC;
        if (m97)
            y = W'(cx + inc97);
        else if (!step[0])
            y = W'(cx - (sx >>> 1));
        else
            y = W'(cx + ((sx + PW'(2)) >>> 2));
    end
endmodule

// File: rtl/lift_scale_sat.sv
// Output stage. In 9/7 mode it applies the band gain to the fixed-point
// value (a shift-add product), rounds half up to an integer and clips.
// In 5/3 mode it only clips. Assumes v holds FRAC fraction bits in 9/7 mode.
module lift_scale_sat import lift_pkg::*; #(
    parameter int W     = 28,
    parameter int OUT_W = 11
) (
    input  logic                    m97,
    input  logic                    is_high,
    input  logic signed [W-1:0]     v,
    output logic signed [OUT_W-1:0] q
);
    localparam int     PW   = W + COEF_BITS;
    localparam longint QMAX = (64'sd1 <<< (OUT_W - 1)) - 64'sd1;
    localparam longint QMIN = -(64'sd1 <<< (OUT_W - 1));

    logic signed [PW-1:0] p_hi;
    logic signed [PW-1:0] p_lo;
    logic signed [PW-1:0] full;

    lift_shift_add_mul #(.AW(W), .PW(PW), .COEF(K_HIGH), .CB(COEF_BITS))
        u_khi (.a(v), .p(p_hi));
    lift_shift_add_mul #(.AW(W), .PW(PW), .COEF(K_LOW), .CB(COEF_BITS))
        u_klo (.a(v), .p(p_lo));

    // Scale and round in 9/7 mode, then clip to the output range.
    always_comb begin
        if (m97)
            full = ((is_high ? p_hi : p_lo) + (PW'(1) <<< (2 * FRAC - 1))) >>> (2 * FRAC);
        else
            full = PW'(v);
        if (full > PW'(QMAX))
            q = OUT_W'(QMAX);
        else if (full < PW'(QMIN))
            q = OUT_W'(QMIN);
        else
            q = OUT_W'(full);
    end
endmodule

// File: rtl/lift_dwt_1d.sv
// Forward 1-D lifting wavelet filter for one line at a time.
// It collects a line into the buffer, runs the lifting steps in place (one
// position per cycle, one parity per step, mirror extension at the ends),
// then emits the coefficients in order through the scaling stage.
// Assumes MAX_LEN >= 2. The mode is latched on the first sample of each line.
module lift_dwt_1d import lift_pkg::*; #(
    parameter int IN_W    = 10,
    parameter int OUT_W   = IN_W + 1,
    parameter int MAX_LEN = 64,
    parameter int GUARD   = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mode_97,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic signed [IN_W-1:0]  in_data,
    input  logic                    in_sol,
    input  logic                    in_eol,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_data,
    output logic                    out_high,
    output logic                    out_last
);
    localparam int W  = IN_W + FRAC + GUARD;
    localparam int AW = $clog2(MAX_LEN);
    localparam int CW = $clog2(MAX_LEN + 2);

    lift_state_t st;
    logic [CW-1:0] wptr, len, idx, oidx;
    logic [1:0]    step;
    logic          m97;

    logic [CW-1:0] pos, left_i, right_i;
    logic          take, line_end, cur_m, lift_wr, last_step;
    logic [W-1:0]  load_val, wr_data, ra_data, rb_data, rc_data;
    logic signed [W-1:0]     alu_y;
    logic signed [OUT_W-1:0] scaled;

    assign in_ready  = (st == ST_COLLECT);
    assign take      = in_valid && in_ready;
    assign pos       = in_sol ? '0 : wptr;
    assign line_end  = in_eol || (pos == CW'(MAX_LEN - 1));
    assign cur_m     = (pos == '0) ? mode_97 : m97;
    assign lift_wr   = (st == ST_LIFT) && (idx < len);
    assign last_step = m97 ? (step == 2'd3) : (step == 2'd1);

    // Input sample in the internal format of the line's kernel.
    always_comb begin
        if (cur_m) load_val = W'(in_data) <<< FRAC;
        else       load_val = W'(in_data);
        wr_data = take ? load_val : alu_y;
    end

    // Mirror-extended neighbour positions of the position being lifted.
    always_comb begin
        left_i  = (idx == '0) ? (idx + CW'(1)) : (idx - CW'(1));
        right_i = ((idx + CW'(1)) < len) ? (idx + CW'(1)) : (idx - CW'(1));
    end

    lift_line_buf #(.W(W), .AW(AW), .DEPTH(2 ** AW)) u_buf (
        .clk    (clk),
        .wr_en  (take || lift_wr),
        .wr_addr(take ? AW'(pos) : AW'(idx)),
        .wr_data(wr_data),
        .ra_addr((st == ST_OUT) ? AW'(oidx) : AW'(idx)),
        .rb_addr(AW'(left_i)),
        .rc_addr(AW'(right_i)),
        .ra_data(ra_data),
        .rb_data(rb_data),
        .rc_data(rc_data)
    );

    lift_step_alu #(.W(W)) u_alu (
        .m97   (m97),
        .step  (step),
        .has_nb(len != CW'(1)),
        .c     (ra_data),
        .l     (rb_data),
        .r     (rc_data),
        .y     (alu_y)
    );

    lift_scale_sat #(.W(W), .OUT_W(OUT_W)) u_scale (
        .m97    (m97),
        .is_high(oidx[0]),
        .v      (ra_data),
        .q      (scaled)
    );

    // Control: collect a line, sweep the lifting steps, emit the coefficients.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_COLLECT;
            wptr      <= '0;
            len       <= '0;
            idx       <= '0;
            oidx      <= '0;
            step      <= '0;
            m97       <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_high  <= 1'b0;
            out_last  <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            case (st)
                ST_COLLECT: begin
                    if (take) begin
                        if (pos == '0) m97 <= mode_97;
                        if (line_end) begin
                            len  <= pos + CW'(1);
                            wptr <= '0;
                            step <= '0;
                            idx  <= CW'(1);
                            st   <= ST_LIFT;
                        end else begin
                            wptr <= pos + CW'(1);
                        end
                    end
                end
                ST_LIFT: begin
                    if (idx < len) begin
                        idx <= idx + CW'(2);
                    end else if (last_step) begin
                        oidx <= '0;
                        st   <= ST_OUT;
                    end else begin
                        step <= step + 2'd1;
                        idx  <= step[0] ? CW'(1) : CW'(0);
                    end
                end
                ST_OUT: begin
                    out_valid <= 1'b1;
                    out_data  <= scaled;
                    out_high  <= oidx[0];
                    out_last  <= (oidx == len - CW'(1));
                    if (oidx == len - CW'(1)) st <= ST_COLLECT;
                    else                      oidx <= oidx + CW'(1);
                end
                default: st <= ST_COLLECT;
            endcase
        end
    end

    AST_MIRROR_INRANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LIFT && idx < len && len > CW'(1)) |-> (left_i < len && right_i < len)); // R7
    AST_BUSY_AFTER_EOL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_eol) |=> !in_ready); // R11
    AST_BEAT_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> out_valid); // R2
    AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |=> !out_valid); // R2
    AST_TAG_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> (out_high != $past(out_high))); // R2
    AST_FIRST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> !out_high); // R2
endmodule

// File: tb/lift_dwt_1d_test.sv
module lift_dwt_1d_test;
    localparam int IN_W = 10;
    localparam int OUT_W = 11;
    localparam int MAXL = 64;
    localparam longint C97 [4] = '{-6497, -217, 3616, 1817};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_97 = 1'b0, in_valid = 1'b0, in_sol = 1'b0, in_eol = 1'b0;
    logic signed [IN_W-1:0] in_data = '0;
    logic in_ready, out_valid, out_high, out_last;
    logic signed [OUT_W-1:0] out_data;

    always #5 clk = ~clk;

    lift_dwt_1d #(.IN_W(IN_W), .OUT_W(OUT_W), .MAX_LEN(MAXL)) uut (
        .clk(clk), .rst_n(rst_n), .mode_97(mode_97),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sol(in_sol), .in_eol(in_eol),
        .out_valid(out_valid), .out_data(out_data),
        .out_high(out_high), .out_last(out_last)
    );

    int checks = 0, errors = 0, sat_hits = 0;
    int exp_d[$];
    bit exp_h[$];
    bit exp_l[$];
    string exp_t[$];
    int line_in[$];
    bit line_m;
    int stim[MAXL];
    longint got[MAXL];
    int gi = 0;
    int md;
    bit mh, ml;
    string mt;

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int mir(int j, int n);
        if (j < 0) return 1;
        if (j >= n) return n - 2;
        return j;
    endfunction

    // Arithmetic model of one line; pushes the expected beats.
    task automatic model_line(string extra);
        int n = line_in.size();
        longint v[MAXL];
        longint sum, o;
        int nst;
        string t;
        for (int i = 0; i < n; i++)
            v[i] = line_m ? (longint'(line_in[i]) <<< 12) : longint'(line_in[i]);
        nst = line_m ? 4 : 2;
        for (int s = 0; s < nst; s++) begin
            for (int i = (s % 2 == 0) ? 1 : 0; i < n; i += 2) begin
                sum = (n > 1) ? (v[mir(i - 1, n)] + v[mir(i + 1, n)]) : 64'sd0;
                if (!line_m) v[i] = (s == 0) ? v[i] - (sum >>> 1) : v[i] + ((sum + 2) >>> 2);
                else v[i] = v[i] + ((sum * C97[s] + 2048) >>> 12);
            end
        end
        for (int i = 0; i < n; i++) begin
            o = line_m ? ((v[i] * ((i % 2) ? 5039 : 3330) + (64'sd1 <<< 23)) >>> 24) : v[i];
            t = line_m ? "R5/R6" : ((i % 2) ? "R3" : "R4");
            if (n > 1 && (i == 0 || i == n - 1)) t = {t, " R7"};
            if (n == 1) t = {t, " R7"};
            if (o > 1023) begin o = 1023; t = {t, " R12"}; sat_hits++; end
            else if (o < -1024) begin o = -1024; t = {t, " R12"}; sat_hits++; end
            if (extra.len() > 0) t = {t, " ", extra};
            exp_d.push_back(int'(o));
            exp_h.push_back(i % 2 == 1);
            exp_l.push_back(i == n - 1);
            exp_t.push_back(t);
        end
        line_in.delete();
    endtask

    // Compare each output beat with the model, every clock.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_d.size() == 0) begin
                chk(0, "R2", "unexpected coefficient", out_data, 0);
            end else begin
                md = exp_d.pop_front();
                mh = exp_h.pop_front();
                ml = exp_l.pop_front();
                mt = exp_t.pop_front();
                chk(out_data == md, mt, "coefficient", out_data, md);
                chk({out_high, out_last} == {mh, ml}, "R2", "high/last tags",
                    {out_high, out_last}, {mh, ml});
            end
            got[gi] = out_data;
            gi = out_last ? 0 : gi + 1;
        end
    end

    task automatic fill_rand(int n);
        for (int i = 0; i < n; i++) stim[i] = int'($urandom_range(0, 1023)) - 512;
    endtask

    task automatic send_line(int n, bit m, bit flip, bit eol_on, string extra);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            in_valid = 1'b1;
            in_data  = IN_W'(stim[i]);
            in_sol   = (i == 0);
            in_eol   = eol_on && (i == n - 1);
            mode_97  = (flip && i > 0) ? ~m : m;
            @(posedge clk);
            if (i == 0) begin line_in.delete(); line_m = m; end
            line_in.push_back(stim[i]);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sol = 1'b0; in_eol = 1'b0;
        if (eol_on || n == MAXL) model_line(extra);
    endtask

    // Offer junk samples while the block is busy (R11).
    task automatic poke_busy();
        chk(in_ready == 1'b0, "R11", "in_ready while busy", in_ready, 0);
        while (!in_ready) begin
            in_valid = 1'b1; in_sol = 1'b1; in_eol = 1'b1;
            in_data = IN_W'(-300); mode_97 = ~mode_97;
            @(negedge clk);
        end
        in_valid = 1'b0; in_sol = 1'b0; in_eol = 1'b0;
    endtask

    task automatic drain();
        while (exp_d.size() != 0 || !in_ready) @(negedge clk);
        @(negedge clk);
    endtask

    // Inverse 5/3 lifting of the last line's outputs (R4).
    task automatic recon(int n);
        longint x[MAXL];
        longint s;
        for (int i = 0; i < n; i++) x[i] = got[i];
        for (int i = 0; i < n; i += 2) begin
            s = (n > 1) ? (x[mir(i - 1, n)] + x[mir(i + 1, n)]) : 64'sd0;
            x[i] = x[i] - ((s + 2) >>> 2);
        end
        for (int i = 1; i < n; i += 2) begin
            s = x[mir(i - 1, n)] + x[mir(i + 1, n)];
            x[i] = x[i] + (s >>> 1);
        end
        for (int i = 0; i < n; i++)
            chk(x[i] == longint'(stim[i]), "R4", "reconstructed sample", x[i], stim[i]);
    endtask

    initial begin
        int lens[10] = '{1, 2, 3, 4, 5, 8, 13, 31, 63, 64};
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);

        for (int k = 0; k < 10; k++) begin
            for (int m = 0; m < 2; m++) begin
                fill_rand(lens[k]);
                send_line(lens[k], m[0], 1'b0, 1'b1, "");
                drain();
                if (m == 0) recon(lens[k]);
            end
        end

        for (int k = 0; k < 8; k++) begin
            int n = int'($urandom_range(1, MAXL));
            fill_rand(n);
            send_line(n, k[0], 1'b0, 1'b1, "R11");
            poke_busy();
            drain();
        end

        for (int i = 0; i < 16; i++) stim[i] = (i % 2) ? 511 : -512;
        send_line(16, 1'b1, 1'b0, 1'b1, "");
        drain();
        chk(sat_hits > 0, "R12", "clipped coefficients seen", sat_hits, 1);

        fill_rand(20);
        send_line(20, 1'b1, 1'b1, 1'b1, "R8");
        drain();
        fill_rand(21);
        send_line(21, 1'b0, 1'b1, 1'b1, "R8");
        drain();

        fill_rand(5);
        send_line(5, 1'b0, 1'b0, 1'b0, "");
        fill_rand(9);
        send_line(9, 1'b1, 1'b0, 1'b1, "R9");
        drain();

        fill_rand(MAXL);
        send_line(MAXL, 1'b0, 1'b0, 1'b0, "R10");
        drain();
        recon(MAXL);

        chk(exp_d.size() == 0, "R2", "pending expected beats", exp_d.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R2 watchdog expired: actual %0d expected %0d", exp_d.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule